// File: doc/BRIEF.md
# Byte-Bus Accumulator Processor Core

A small multi-cycle processor that fetches and executes a handful of accumulator-load and branch instructions over a byte-wide memory port. Every memory access takes exactly one clock and one bus cycle. The port has a 16-bit address, 8-bit read data and 8-bit write data, an access-enable line and a read/write line. The memory must answer in the same cycle as the address.

An instruction runs as a fixed sequence of steps. First comes the opcode fetch, then zero to two operand fetches. Memory-reading modes then spend one bus-idle cycle forming the effective address, followed by the data read. Decode happens in the cycle where the byte arrives and costs no extra clock.

Out of reset the core reads a 16-bit start address from the top two bytes of memory before its first opcode fetch. The accumulator, index register, program counter, condition codes and effective-address register are brought out as ports. A marker output shows each opcode-fetch cycle, so a system can count the cycles taken by each instruction.

Top module: `acc8_core`

## Requirements
- R1: After reset the core reads address $FFFE, then $FFFF, in two consecutive bus cycles. It loads the PC with (first byte << 8) | second byte and fetches its first opcode from that address in the next cycle.
- R2: Opcode $87 takes one byte, one clock and one bus cycle. It sets A to zero.
- R3: Opcode $86 takes two bytes, two clocks and two bus cycles. It loads A with the byte that follows the opcode.
- R4: Opcode $96 loads A from address {$00, operand}. It takes three bus cycles over four clocks, and the address-forming cycle has no bus access.
- R5: Opcode $B6 loads A from the address held in its next two bytes, the first being the high byte. It takes four bus cycles over five clocks.
- R6: Opcode $A6 with postbyte $00 loads A from the address held in X, in three bus cycles over four clocks. With any other postbyte it ends after two cycles and leaves A and the flags unchanged.
- R7: Opcode $20 rr sets PC to (instruction address + 2 + rr), with rr sign-extended. It takes two clocks, and $20 $FE branches to itself.
- R8: Each fetched instruction byte comes from the address that follows the previous one. The PC advances by one after each fetched byte.
- R9: Every load or clear updates the CCR as follows: bit 2 (Z) is set when the new A is zero, bit 3 (N) takes bit 7 of A, bit 1 (V) is cleared, and bit 0 (C) is left unchanged.
- R10: Any other opcode is a one-byte, one-clock no-op. It leaves A and the CCR unchanged.
- R11: The core only reads. Whenever an access is enabled the read/write line is high (read) and the write data is zero.
- R12: The memory-reading modes put the formed address into the visible EA register. The data read goes out on that address, and the register keeps its value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Bus address |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_wdata | output | 8 | Write data (always zero) |
| mem_en | output | 1 | Bus access this cycle |
| mem_rw | output | 1 | 1 = read, 0 = write |
| acc | output | 8 | Accumulator A |
| ix | output | 16 | Index register X |
| pc | output | 16 | Program counter |
| ear | output | 16 | Effective-address register |
| ccr | output | 8 | Condition codes, N=3 Z=2 V=1 C=0 |
| op_fetch | output | 1 | High in each opcode-fetch cycle |

## Verification
The bench builds the core with its index register reset to $12B7. A zero-offset indexed load therefore reads a byte that the bench memory makes zero, so the Z path is reachable through the indexed mode without any instruction that writes X. The reset vector is left at $FFFE, and the program sits at $4000. Data bytes elsewhere are a computed function of the address. This lets direct, extended and indexed reads each return a distinct, checkable value, including both a negative result and a zero result.

// File: rtl/acc8_pkg.sv
package acc8_pkg;
    localparam int AW = 16;
    localparam int DW = 8;

    localparam logic [DW-1:0] OPC_CLR = 8'h87;
    localparam logic [DW-1:0] OPC_IMM = 8'h86;
    localparam logic [DW-1:0] OPC_DIR = 8'h96;
    localparam logic [DW-1:0] OPC_EXT = 8'hB6;
    localparam logic [DW-1:0] OPC_IDX = 8'hA6;
    localparam logic [DW-1:0] OPC_BRA = 8'h20;

    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;

    typedef enum logic [2:0] {
        ST_VHI, ST_VLO, ST_OP, ST_B1, ST_B2, ST_EA, ST_RD
    } state_e;

    typedef enum logic [2:0] {
        M_NONE, M_CLR, M_IMM, M_DIR, M_EXT, M_IDX, M_BRA
    } mode_e;

    typedef struct packed {
        state_e        st;
        logic [DW-1:0] ir;
        logic [DW-1:0] a;
        logic [AW-1:0] x;
        logic [AW-1:0] pc;
        logic [AW-1:0] ear;
        logic [DW-1:0] cc;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } core_s;
endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
    import acc8_pkg::*;
(
    input  logic [DW-1:0] opcode,
    output mode_e         mode
);
    always_comb begin
        case (opcode)
            OPC_CLR: mode = M_CLR;
            OPC_IMM: mode = M_IMM;
            OPC_DIR: mode = M_DIR;
            OPC_EXT: mode = M_EXT;
            OPC_IDX: mode = M_IDX;
            OPC_BRA: mode = M_BRA;
            default: mode = M_NONE;
        endcase
    end
endmodule

// File: rtl/acc8_agen.sv
module acc8_agen
    import acc8_pkg::*;
(
    input  mode_e         mode,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] opnd_lo,
    input  logic [AW-1:0] index,
    input  logic [AW-1:0] pc_after,
    input  logic [DW-1:0] rel,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] br_target
);
    localparam int EXT_W = AW - DW;

    always_comb begin
        case (mode)
            M_DIR:   ea = {{EXT_W{1'b0}}, opnd_lo};
            M_EXT:   ea = {opnd_hi, opnd_lo};
            M_IDX:   ea = index;
            default: ea = '0;
        endcase
        br_target = pc_after + {{EXT_W{rel[DW-1]}}, rel};
    end
endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_pkg::*;
#(
    parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE,
    parameter logic [AW-1:0] IX_INIT  = 16'h0000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_en,
    output logic          mem_rw,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] ix,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ear,
    output logic [DW-1:0] ccr,
    output logic          op_fetch
);
    localparam logic [AW-1:0] VEC_ADDR_LO = VEC_ADDR + 16'd1;

    core_s         r_q, r_d;
    mode_e         mode_new, mode_cur;
    logic [AW-1:0] ea_calc, br_calc;
    logic          load_now;
    logic [DW-1:0] load_val;

    acc8_decode u_dec_new (.opcode(mem_rdata), .mode(mode_new));
    acc8_decode u_dec_cur (.opcode(r_q.ir),    .mode(mode_cur));

    acc8_agen u_agen (
        .mode      (mode_cur),
        .opnd_hi   (r_q.hi),
        .opnd_lo   (r_q.lo),
        .index     (r_q.x),
        .pc_after  (r_q.pc + 16'd1),
        .rel       (mem_rdata),
        .ea        (ea_calc),
        .br_target (br_calc)
    );

    always_comb begin
        r_d       = r_q;
        mem_en    = 1'b0;
        mem_rw    = 1'b1;
        mem_wdata = '0;
        mem_addr  = r_q.pc;
        load_now  = 1'b0;
        load_val  = '0;
        case (r_q.st)
            ST_VHI: begin
                mem_en   = 1'b1;
                mem_addr = VEC_ADDR;
                r_d.hi   = mem_rdata;
                r_d.st   = ST_VLO;
            end
            ST_VLO: begin
                mem_en   = 1'b1;
                mem_addr = VEC_ADDR_LO;
                r_d.pc   = {r_q.hi, mem_rdata};
                r_d.st   = ST_OP;
            end
            ST_OP: begin
                mem_en = 1'b1;
                r_d.ir = mem_rdata;
                r_d.pc = r_q.pc + 16'd1;
                case (mode_new)
                    M_NONE:  r_d.st = ST_OP;
                    M_CLR: begin
                        load_now = 1'b1;
                        r_d.st   = ST_OP;
                    end
                    default: r_d.st = ST_B1;
                endcase
            end
            ST_B1: begin
                mem_en = 1'b1;
                r_d.pc = r_q.pc + 16'd1;
                r_d.lo = mem_rdata;
                r_d.st = ST_OP;
                case (mode_cur)
                    M_IMM: begin
                        load_now = 1'b1;
                        load_val = mem_rdata;
                    end
                    M_BRA: r_d.pc = br_calc;
                    M_DIR: r_d.st = ST_EA;
                    M_EXT: begin
                        r_d.hi = mem_rdata;
                        r_d.st = ST_B2;
                    end
                    M_IDX: if (mem_rdata == '0) r_d.st = ST_EA;
                    default: r_d.st = ST_OP;
                endcase
            end
            ST_B2: begin
                mem_en = 1'b1;
                r_d.pc = r_q.pc + 16'd1;
                r_d.lo = mem_rdata;
                r_d.st = ST_EA;
            end
            ST_EA: begin
                r_d.ear = ea_calc;
                r_d.st  = ST_RD;
            end
            ST_RD: begin
                mem_en   = 1'b1;
                mem_addr = r_q.ear;
                load_now = 1'b1;
                load_val = mem_rdata;
                r_d.st   = ST_OP;
            end
            default: r_d.st = ST_OP;
        endcase
        if (load_now) begin
            r_d.a       = load_val;
            r_d.cc[CC_Z] = (load_val == '0);
            r_d.cc[CC_N] = load_val[DW-1];
            r_d.cc[CC_V] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_VHI;
            r_q.x   <= IX_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc      = r_q.a;
    assign ix       = r_q.x;
    assign pc       = r_q.pc;
    assign ear      = r_q.ear;
    assign ccr      = r_q.cc;
    assign op_fetch = (r_q.st == ST_OP);

    AST_VEC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_VHI) |=> (r_q.st == ST_VLO) && ($past(mem_addr) == VEC_ADDR)); // R1

    AST_EA_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EA) |-> !mem_en); // R4

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (r_q.st == ST_OP || r_q.st == ST_B2)) |=> (r_q.pc == $past(r_q.pc) + 16'd1)); // R8

    AST_READ_VIA_EAR: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD) |-> (mem_addr == r_q.ear) && ($past(r_q.st) == ST_EA)); // R12

    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (r_q.cc[CC_Z] == (r_q.a == '0)) && (r_q.cc[CC_N] == r_q.a[DW-1])
                     && !r_q.cc[CC_V] && (r_q.cc[CC_C] == $past(r_q.cc[CC_C]))); // R9

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OP && mode_new == M_NONE) |=> $stable(r_q.a) && $stable(r_q.cc)
                                                    && (r_q.st == ST_OP)); // R10

    AST_BRA_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_B1 && mode_cur == M_BRA)
        |=> (r_q.pc == $past(r_q.pc) + 16'd1 + {{8{$past(mem_rdata[7])}}, $past(mem_rdata)})); // R7
endmodule

// File: tb/acc8_core_test.sv
module acc8_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [1:0]  sz;
        logic        pad;
        logic        rep;
        logic [7:0]  a;
        logic        z;
        logic        n;
        logic [3:0]  nbus;
        logic [3:0]  nclk;
        logic        chk_ea;
        logic [15:0] ea;
        logic [3:0]  req;
    } vec_t;

    // Data bytes outside the program: addr[7:0] ^ addr[15:8] ^ $A5.
    localparam vec_t TBL [NV] = '{
        '{8'h86, 8'h00, 8'h00, 2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd3}, // R3 zero
        '{8'h86, 8'h7F, 8'h00, 2'd2, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd3}, // R3
        '{8'h87, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd1, 4'd1, 1'b0, 16'h0000, 4'd2}, // R2
        '{8'h96, 8'h32, 8'h00, 2'd2, 1'b0, 1'b0, 8'h97, 1'b0, 1'b1, 4'd3, 4'd4, 1'b1, 16'h0032, 4'd4}, // R4
        '{8'hB6, 8'h38, 8'h00, 2'd3, 1'b0, 1'b0, 8'h9D, 1'b0, 1'b1, 4'd4, 4'd5, 1'b1, 16'h3800, 4'd5}, // R5
        '{8'h86, 8'h81, 8'h00, 2'd2, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd9}, // R9
        '{8'h96, 8'hA5, 8'h00, 2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd3, 4'd4, 1'b1, 16'h00A5, 4'd4}, // R4 zero
        '{8'h86, 8'h05, 8'h00, 2'd2, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd3}, // R3
        '{8'hA6, 8'h00, 8'h00, 2'd2, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd3, 4'd4, 1'b1, 16'h12B7, 4'd6}, // R6
        '{8'h86, 8'h05, 8'h00, 2'd2, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd3}, // R3
        '{8'hA6, 8'h10, 8'h00, 2'd2, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd6}, // R6 bad postbyte
        '{8'h01, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 4'd1, 4'd1, 1'b0, 16'h0000, 4'd10}, // R10
        '{8'h20, 8'h02, 8'h00, 2'd2, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd7}, // R7 forward
        '{8'h20, 8'hFE, 8'h00, 2'd2, 1'b0, 1'b0, 8'h05, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd7}, // R7 self
        '{8'h20, 8'hFE, 8'h00, 2'd2, 1'b0, 1'b1, 8'h05, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0, 16'h0000, 4'd7}  // R7 again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, ix, pc, ear;
    logic [7:0]  mem_rdata, mem_wdata, acc, ccr;
    logic        mem_en, mem_rw, op_fetch;
    logic [7:0]  prog [256];
    int          checks = 0;
    int          errors = 0;
    int          bus_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        if (a[15:8] == 8'h40) return prog[a[7:0]];
        if (a == 16'hFFFE) return 8'h40;
        if (a == 16'hFFFF) return 8'h00;
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    acc8_core #(.VEC_ADDR(16'hFFFE), .IX_INIT(16'h12B7)) uut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_en(mem_en), .mem_rw(mem_rw), .acc(acc),
        .ix(ix), .pc(pc), .ear(ear), .ccr(ccr), .op_fetch(op_fetch)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    // R11: read-only bus, observed on every enabled cycle
    always @(negedge clk) if (rst_n && mem_en && (!mem_rw || mem_wdata != 8'h00)) bus_bad++;

    initial begin
        logic [15:0] pc_exp, start, nxt;
        logic [15:0] seen [8];
        int          wp, nclk, nbus;
        for (int k = 0; k < 256; k++) prog[k] = 8'h01;
        wp = 0;
        for (int i = 0; i < NV; i++) begin
            if (!TBL[i].rep) begin
                prog[wp] = TBL[i].op; wp++;
                if (TBL[i].sz > 2'd1) begin prog[wp] = TBL[i].b1; wp++; end
                if (TBL[i].sz > 2'd2) begin prog[wp] = TBL[i].b2; wp++; end
                if (TBL[i].pad) begin prog[wp] = 8'h86; prog[wp+1] = 8'hEE; wp += 2; end
            end
        end

        repeat (3) @(negedge clk);
        check(acc == 8'h00, "R1", "reset acc", acc, 8'h00);
        check(ccr == 8'h00, "R9", "reset ccr", ccr, 8'h00);
        check(!op_fetch, "R1", "no fetch in reset", op_fetch, 0);
        rst_n = 1'b1;
        check(mem_en && mem_addr == 16'hFFFE, "R1", "vector high addr", mem_addr, 16'hFFFE);
        @(negedge clk);
        check(mem_en && mem_addr == 16'hFFFF, "R1", "vector low addr", mem_addr, 16'hFFFF);
        @(negedge clk);
        check(op_fetch && pc == 16'h4000, "R1", "first fetch pc", pc, 16'h4000);
        check(mem_addr == 16'h4000, "R1", "first fetch addr", mem_addr, 16'h4000);

        pc_exp = 16'h4000;
        for (int i = 0; i < NV; i++) begin
            string rq;
            rq    = $sformatf("R%0d", TBL[i].req);
            start = pc_exp;
            nclk  = 0;
            nbus  = 0;
            do begin
                nclk++;
                if (mem_en) begin
                    if (nbus < 8) seen[nbus] = mem_addr;
                    nbus++;
                end
                @(negedge clk);
            end while (!op_fetch && nclk < 20);
            if (TBL[i].op == 8'h20) nxt = start + 16'd2 + {{8{TBL[i].b1[7]}}, TBL[i].b1};
            else nxt = start + {14'd0, TBL[i].sz} + (TBL[i].pad ? 16'd2 : 16'd0) * 16'd0;
            check(acc == TBL[i].a, rq, $sformatf("vec %0d acc", i), acc, TBL[i].a);
            check(ccr[2] == TBL[i].z, "R9", $sformatf("vec %0d Z", i), ccr[2], TBL[i].z);
            check(ccr[3] == TBL[i].n, "R9", $sformatf("vec %0d N", i), ccr[3], TBL[i].n);
            check(ccr[1:0] == 2'b00, "R9", $sformatf("vec %0d V/C", i), ccr[1:0], 0);
            check(nbus == int'(TBL[i].nbus), rq, $sformatf("vec %0d bus cycles", i), nbus, TBL[i].nbus);
            check(nclk == int'(TBL[i].nclk), rq, $sformatf("vec %0d clocks", i), nclk, TBL[i].nclk);
            check(pc == nxt, (TBL[i].op == 8'h20) ? "R7" : "R8", $sformatf("vec %0d next pc", i), pc, nxt);
            for (int k = 0; k < int'(TBL[i].sz); k++)
                check(seen[k] == start + 16'(k), "R8", $sformatf("vec %0d byte %0d addr", i, k),
                      seen[k], start + 16'(k));
            if (TBL[i].chk_ea) begin
                check(ear == TBL[i].ea, "R12", $sformatf("vec %0d ear", i), ear, TBL[i].ea);
                check(seen[nbus-1] == TBL[i].ea, "R12", $sformatf("vec %0d read addr", i),
                      seen[nbus-1], TBL[i].ea);
            end
            pc_exp = nxt;
        end
        check(ear == 16'h12B7, "R12", "ear kept after non-memory ops", ear, 16'h12B7);
        check(bus_bad == 0, "R11", "read-only bus", bus_bad, 0);
        finish_run();
    end
endmodule